// File: doc/BRIEF.md
# Bidirectional GPIO Port with Direction Control

This block is an 8-bit general-purpose I/O port that sits on a simple CPU bus. It has an address, write and read strobes, and 8-bit write and read data. Software sees two registers. The output data latch is at offset 0x3 and holds the values the pins drive. The direction register is at offset 0x7 and decides, pin by pin, whether the output driver is on. Each pad gets a drive value and an output-enable. Each pad's input level passes through a two-flop synchronizer before software can read it.

Every pin is in one of three modes at any moment:
- `PIN_INPUT`: direction bit 0. The driver is off.
- `PIN_OUTPUT`: direction bit 1. The driver is on and carries the latch bit.
- `PIN_SPI`: only pins 6 and 7, while the serial-interface enable is high. The serial peripheral's own data and enable drive the pad.

The transitions between modes are:
- INPUT↔OUTPUT: a write to the direction register, taking effect on that clock edge.
- INPUT/OUTPUT→SPI: `spi_en` rising.
- SPI→INPUT/OUTPUT: `spi_en` falling. The pin returns to whatever mode its unchanged direction bit selects.

The data latch is always writable, so software can preload a value before it turns a pin into an output. A read of the data offset mixes two sources bit by bit: the latch for output pins and the synchronized pad level for input pins.

Top module: `gpio_dirport`

## Requirements
- R1: After reset the direction register and the data latch are both 0x00, every `pin_oe` bit is 0 and every `pin_out` bit is 0.
- R2: A write to offset 0x7 loads the direction register, and a read of offset 0x7 returns it. While `spi_en` is low, `pin_oe[i]` equals direction bit i (1 = driver enabled, 0 = input).
- R3: A write to offset 0x3 loads the data latch whatever the direction bits hold. For pins that the serial interface does not own, `pin_out` always equals the latch, so a pin switched to output presents the preloaded value on the same edge, with no intermediate value.
- R4: A read of offset 0x3 returns, for each bit i, the latch bit when direction bit i is 1 and the synchronized pad level when direction bit i is 0.
- R5: A change on `pin_in` becomes visible to reads after exactly two rising clock edges. After one edge the old level is still returned.
- R6: While `spi_en` is high, pin 6 drives `spi_mosi_o` with enable `spi_mosi_oe`, and pin 7 drives `spi_miso_o` with enable `spi_miso_oe`. Direction bits 6 and 7 have no effect on these pads.
- R7: Raising or lowering `spi_en` leaves the direction register and the data latch unchanged. After `spi_en` falls, pins 6 and 7 again follow R2 and R3.
- R8: A read of any offset other than 0x3 or 0x7 returns 0x00, and `bus_rdata` is 0x00 whenever `bus_rd` is low. A write to any other offset changes no register.
- R9: A register write takes effect on the rising edge at which `bus_wr` is sampled high. `pin_out` and `pin_oe` change on that same edge and not before it.
- R10: `spi_mosi_i` and `spi_miso_i` carry the synchronized levels of pins 6 and 7, with the same two-edge delay as R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 3 | Register offset |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_rd | input | 1 | Read strobe, which gates `bus_rdata` |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational) |
| pin_in | input | 8 | Pad input levels (asynchronous) |
| pin_out | output | 8 | Pad drive values |
| pin_oe | output | 8 | Pad output-enables |
| spi_en | input | 1 | Serial interface claims pins 6 and 7 |
| spi_mosi_o | input | 1 | Serial data out for pin 6 |
| spi_mosi_oe | input | 1 | Driver enable for pin 6 in serial mode |
| spi_miso_o | input | 1 | Serial data out for pin 7 |
| spi_miso_oe | input | 1 | Driver enable for pin 7 in serial mode |
| spi_mosi_i | output | 1 | Synchronized level of pin 6 |
| spi_miso_i | output | 1 | Synchronized level of pin 7 |

## Verification
The bench preloads the latch while every pin is an input and then flips the direction bits. A design that gated `pin_out` with the direction, or that reset the latch on a direction change, would show a stale or zero value at the moment of the switch. The bench also reads the data offset with a mixed direction mask and with a fresh pad change pending. A design that read the raw pad, read only the latch, or had one synchronizer stage too few or too many returns the new level one edge too early or too late. It toggles `spi_en` with direction bits set against the serial enables and then reads both registers back. A design that let the direction leak onto pins 6 and 7, or that cleared registers on takeover, shows up in `pin_oe` or in the readback. Writes and reads to unmapped offsets catch a decoder that aliases addresses.

// File: rtl/gpio_dirport_pkg.sv
package gpio_dirport_pkg;
    typedef enum logic [1:0] {
        PIN_INPUT  = 2'd0,
        PIN_OUTPUT = 2'd1,
        PIN_SPI    = 2'd2
    } pin_mode_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_raw,
    output logic [W-1:0] pin_sync
);
    logic [W-1:0] stage1_q;
    logic [W-1:0] stage2_q;
    logic [1:0]   age_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= pin_raw;
            stage2_q <= stage1_q;
        end
    end

    // cycles since reset, saturating; used only to arm the checker below
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              age_q <= 2'd0;
        else if (age_q != 2'd2)  age_q <= age_q + 2'd1;
    end

    assign pin_sync = stage2_q;

    // R5 / R10: synchronized level equals the pad level two edges earlier
    a_r5_two_stage_delay: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q == 2'd2) |-> (pin_sync == $past(pin_raw, 2)));
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs #(
    parameter int W        = 8,
    parameter int ADDR_W   = 3,
    parameter int DATA_OFS = 3,
    parameter int DIR_OFS  = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [W-1:0]      bus_wdata,
    input  logic [W-1:0]      pin_level,
    output logic [W-1:0]      latch_q,
    output logic [W-1:0]      dir_q,
    output logic [W-1:0]      bus_rdata
);
    localparam logic [ADDR_W-1:0] DATA_A = ADDR_W'(DATA_OFS);
    localparam logic [ADDR_W-1:0] DIR_A  = ADDR_W'(DIR_OFS);

    logic hit_data;
    logic hit_dir;

    assign hit_data = (bus_addr == DATA_A);
    assign hit_dir  = (bus_addr == DIR_A);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            latch_q <= '0;
            dir_q   <= '0;
        end else if (bus_wr) begin
            if (hit_data) latch_q <= bus_wdata;
            if (hit_dir)  dir_q   <= bus_wdata;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            if (hit_data)     bus_rdata = (latch_q & dir_q) | (pin_level & ~dir_q);
            else if (hit_dir) bus_rdata = dir_q;
        end
    end

    // R2: a direction write lands on the next edge
    a_r2_dir_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && hit_dir) |=> (dir_q == $past(bus_wdata)));
    // R3: latch write accepted regardless of direction
    a_r3_latch_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && hit_data) |=> (latch_q == $past(bus_wdata)));
    // R8: writes elsewhere change nothing
    a_r8_unmapped_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !hit_data && !hit_dir) |=> ($stable(latch_q) && $stable(dir_q)));
    // R8: idle bus reads as zero
    a_r8_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |-> (bus_rdata == '0));
endmodule

// File: rtl/gpio_pinmux.sv
module gpio_pinmux
    import gpio_dirport_pkg::*;
#(
    parameter int W        = 8,
    parameter int MOSI_IDX = 6,
    parameter int MISO_IDX = 7
) (
    input  logic [W-1:0] latch_q,
    input  logic [W-1:0] dir_q,
    input  logic         spi_en,
    input  logic         spi_mosi_o,
    input  logic         spi_mosi_oe,
    input  logic         spi_miso_o,
    input  logic         spi_miso_oe,
    output logic [W-1:0] pin_out,
    output logic [W-1:0] pin_oe
);
    for (genvar i = 0; i < W; i++) begin : g_pin
        localparam bit IS_MOSI = (i == MOSI_IDX);
        localparam bit IS_MISO = (i == MISO_IDX);
        localparam bit SHARED  = IS_MOSI || IS_MISO;

        pin_mode_e mode;

        always_comb begin
            if (SHARED && spi_en) mode = PIN_SPI;
            else if (dir_q[i])    mode = PIN_OUTPUT;
            else                  mode = PIN_INPUT;
        end

        always_comb begin
            unique case (mode)
                PIN_INPUT: begin
                    pin_out[i] = latch_q[i];
                    pin_oe[i]  = 1'b0;
                end
                PIN_OUTPUT: begin
                    pin_out[i] = latch_q[i];
                    pin_oe[i]  = 1'b1;
                end
                PIN_SPI: begin
                    pin_out[i] = IS_MOSI ? spi_mosi_o  : spi_miso_o;
                    pin_oe[i]  = IS_MOSI ? spi_mosi_oe : spi_miso_oe;
                end
                default: begin
                    pin_out[i] = latch_q[i];
                    pin_oe[i]  = 1'b0;
                end
            endcase
        end
    end
endmodule

// File: rtl/gpio_dirport.sv
module gpio_dirport #(
    parameter int W        = 8,
    parameter int ADDR_W   = 3,
    parameter int DATA_OFS = 3,
    parameter int DIR_OFS  = 7,
    parameter int MOSI_IDX = 6,
    parameter int MISO_IDX = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [W-1:0]      bus_wdata,
    output logic [W-1:0]      bus_rdata,
    input  logic [W-1:0]      pin_in,
    output logic [W-1:0]      pin_out,
    output logic [W-1:0]      pin_oe,
    input  logic              spi_en,
    input  logic              spi_mosi_o,
    input  logic              spi_mosi_oe,
    input  logic              spi_miso_o,
    input  logic              spi_miso_oe,
    output logic              spi_mosi_i,
    output logic              spi_miso_i
);
    logic [W-1:0] pin_level;
    logic [W-1:0] latch_q;
    logic [W-1:0] dir_q;

    gpio_sync #(.W(W)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_raw  (pin_in),
        .pin_sync (pin_level)
    );

    gpio_regs #(
        .W(W), .ADDR_W(ADDR_W), .DATA_OFS(DATA_OFS), .DIR_OFS(DIR_OFS)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_wdata (bus_wdata),
        .pin_level (pin_level),
        .latch_q   (latch_q),
        .dir_q     (dir_q),
        .bus_rdata (bus_rdata)
    );

    gpio_pinmux #(
        .W(W), .MOSI_IDX(MOSI_IDX), .MISO_IDX(MISO_IDX)
    ) u_mux (
        .latch_q     (latch_q),
        .dir_q       (dir_q),
        .spi_en      (spi_en),
        .spi_mosi_o  (spi_mosi_o),
        .spi_mosi_oe (spi_mosi_oe),
        .spi_miso_o  (spi_miso_o),
        .spi_miso_oe (spi_miso_oe),
        .pin_out     (pin_out),
        .pin_oe      (pin_oe)
    );

    assign spi_mosi_i = pin_level[MOSI_IDX];
    assign spi_miso_i = pin_level[MISO_IDX];

    // R2: with the serial interface idle, enables mirror the direction register
    a_r2_oe_tracks_dir: assert property (@(posedge clk) disable iff (!rst_n)
        !spi_en |-> (pin_oe == dir_q));
    // R6: serial interface owns the two shared pads
    a_r6_spi_pads: assert property (@(posedge clk) disable iff (!rst_n)
        spi_en |-> (pin_oe[MOSI_IDX] == spi_mosi_oe && pin_oe[MISO_IDX] == spi_miso_oe &&
                    pin_out[MOSI_IDX] == spi_mosi_o && pin_out[MISO_IDX] == spi_miso_o));
    // R7: takeover leaves registers untouched
    a_r7_regs_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_en != $past(spi_en) && !$past(bus_wr)) |-> ($stable(dir_q) && $stable(latch_q)));
endmodule

// File: tb/tb_gpio_dirport.sv
`timescale 1ns/1ps
module tb_gpio_dirport;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] bus_addr = '0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [7:0] pin_in = '0;
    logic [7:0] pin_out, pin_oe;
    logic       spi_en = 1'b0, spi_mosi_o = 1'b0, spi_mosi_oe = 1'b0;
    logic       spi_miso_o = 1'b0, spi_miso_oe = 1'b0;
    logic       spi_mosi_i, spi_miso_i;

    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    gpio_dirport dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in), .pin_out(pin_out),
        .pin_oe(pin_oe), .spi_en(spi_en), .spi_mosi_o(spi_mosi_o), .spi_mosi_oe(spi_mosi_oe),
        .spi_miso_o(spi_miso_o), .spi_miso_oe(spi_miso_oe), .spi_mosi_i(spi_mosi_i),
        .spi_miso_i(spi_miso_i)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        bus_rd = 1'b0;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        check("R1 oe", pin_oe, 8'h00);
        check("R1 out", pin_out, 8'h00);
        rd(3'd7, v); check("R1 dir", v, 8'h00);
        rd(3'd3, v); check("R1 data", v, 8'h00);
    endtask

    task automatic t_direction();
        logic [7:0] v;
        wr(3'd7, 8'hA5);
        rd(3'd7, v); check("R2 dir readback", v, 8'hA5);
        check("R2 oe", pin_oe, 8'hA5);
        wr(3'd7, 8'h00);
        check("R2 oe cleared", pin_oe, 8'h00);
    endtask

    task automatic t_preload();
        wr(3'd3, 8'h3C);
        check("R3 out while input", pin_out, 8'h3C);
        check("R3 oe while input", pin_oe, 8'h00);
        wr(3'd7, 8'hFF);
        check("R3 out after switch", pin_out, 8'h3C);
        check("R3 oe after switch", pin_oe, 8'hFF);
    endtask

    task automatic t_mixed_read();
        logic [7:0] v;
        wr(3'd7, 8'h0F);
        wr(3'd3, 8'h05);
        @(negedge clk); pin_in = 8'hAA;
        @(posedge clk); @(posedge clk);
        rd(3'd3, v); check("R4 mixed read", v, 8'hA5);
        @(negedge clk); pin_in = 8'h5A;
        @(posedge clk);
        rd(3'd3, v); check("R5 one edge old", v, 8'hA5);
        @(posedge clk);
        rd(3'd3, v); check("R5 two edges new", v, 8'h55);
    endtask

    task automatic t_spi();
        logic [7:0] v;
        wr(3'd7, 8'hC0);
        wr(3'd3, 8'h00);
        @(negedge clk);
        spi_mosi_o = 1'b1; spi_mosi_oe = 1'b1; spi_miso_o = 1'b1; spi_miso_oe = 1'b0;
        spi_en = 1'b1;
        #1;
        check("R6 oe", pin_oe, 8'h40);
        check("R6 out", pin_out, 8'hC0);
        rd(3'd7, v); check("R7 dir kept", v, 8'hC0);
        @(negedge clk); pin_in = 8'h80;
        @(posedge clk);
        #1 check("R10 one edge old", {7'd0, spi_miso_i}, 8'h00);
        @(posedge clk);
        #1 check("R10 miso in", {6'd0, spi_miso_i, spi_mosi_i}, 8'h02);
        @(negedge clk); spi_en = 1'b0;
        #1;
        check("R7 oe restored", pin_oe, 8'hC0);
        check("R7 out restored", pin_out, 8'h00);
    endtask

    task automatic t_unmapped();
        logic [7:0] v;
        wr(3'd7, 8'h12);
        wr(3'd3, 8'h34);
        wr(3'd1, 8'hFF);
        wr(3'd0, 8'hFF);
        rd(3'd7, v); check("R8 dir untouched", v, 8'h12);
        check("R8 out untouched", pin_out, 8'h34);
        rd(3'd0, v); check("R8 unmapped read", v, 8'h00);
        rd(3'd5, v); check("R8 unmapped read 5", v, 8'h00);
        @(negedge clk); bus_addr = 3'd7; #1;
        check("R8 idle bus", bus_rdata, 8'h00);
    endtask

    task automatic t_edge_timing();
        @(negedge clk);
        bus_addr = 3'd7; bus_wdata = 8'hF0; bus_wr = 1'b1;
        #1 check("R9 before edge", pin_oe, 8'h12);
        @(posedge clk);
        #1 check("R9 after edge", pin_oe, 8'hF0);
        bus_wr = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_direction();
        t_preload();
        t_mixed_read();
        t_spi();
        t_unmapped();
        t_edge_timing();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                n_chk++; n_bad++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule